// File: doc/BRIEF.md
# Instruction-Driven Barrel Shifter with Normaliser

The block shifts a word under control of a 4-bit opcode. It does logical, arithmetic and rotate shifts. The shift distance comes from one of four places: a 4-bit shift-value input, either of two 4-bit amount registers (called R1 and R2), or a leading-sign counter. The counter tells how far a word must move left so that its two top bits differ, which normalises the word.

Each beat carries an opcode, a data word and a shift value, and it enters through a valid/ready handshake. A beat is accepted on a clock edge when `in_valid` and `in_ready` are both high. This edge also latches the opcode, so nothing takes effect before it. The beat then spends one cycle in the execute stage, and its result is registered into the output stage. The output is held until `out_ready` is high while `out_valid` is high. `in_ready` is low only when both stages are full and the output is stalled, so no beat is dropped or duplicated. The two amount registers change on the edge that moves the writing instruction out of the execute stage. A later instruction that reads them therefore sees the new value.

The bidirectional shift-value port appears as three signals: an input, a driven value with its enable, and a flag that says whether the executing opcode reads the input. The opcode in the execute stage decides the port direction. An active-low enable input allows the port to be driven.

Top module: `norm_barrel_shifter`

## Requirements
- R1: When `rst_n` is low at a clock edge, or `clr` is high at a clock edge, the block clears both stages and both amount registers to zero. After that edge `out_valid` is 0 and `in_ready` is 1, and an instruction that shifts by R1 returns its data unchanged.
- R2: Opcode 0 shifts right by the latched shift value and opcode 1 shifts left by it. Vacated bits are filled with zeros and bits leaving the word are lost.
- R3: Opcode 2 rotates right by the latched shift value and opcode 3 rotates left by it. Bits leaving one end re-enter at the other end.
- R4: Opcodes 0xA, 0xB and 0xC shift right arithmetically. The distance is the shift value for 0xA, R1 for 0xB and R2 for 0xC. Vacated upper bits copy the original bit 15.
- R5: Opcodes 4 and 5 shift logically right and left by R1. Opcodes 6 and 7 do the same by R2. The value used is the register's content during the execute cycle.
- R6: Opcode 8 loads the latched shift value into R1 and opcode 9 loads it into R2. The load happens when the instruction leaves the execute stage, and the data word passes through unshifted.
- R7: Opcodes 0xD, 0xE and 0xF shift left, with zero fill, by the count of bits below bit 15 that equal bit 15. The count stops at the first differing bit and is at most 15. For a non-uniform word, bits 15 and 14 of the result differ.
- R8: When the data word is all zeros or all ones, the normalise count is 15.
- R9: Opcode 0xE writes the normalise count into R1 and opcode 0xF writes it into R2. The write happens when the instruction leaves the execute stage.
- R10: During a normalise opcode, `sv_out` carries the count and `sv_drive` equals the inverse of `sv_oe_n`. `sv_listen` is high for opcodes 0–3, 8, 9 and 0xA. Both `sv_drive` and `sv_listen` are low for opcodes 4–7, 0xB and 0xC, and low when the execute stage is empty.
- R11: With `out_ready` held high, a beat accepted on edge k appears on the output after edge k+1. Back-to-back beats are accepted on consecutive edges.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. With both stages full, `in_ready` is low. Stalled beats leave the output in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of pipeline and amount registers |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts a beat this edge |
| in_op | input | 4 | Opcode |
| in_data | input | DATA_W | Data word to shift |
| in_sv | input | AMT_W | Shift value from the port |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | DATA_W | Shifted result |
| sv_oe_n | input | 1 | Active-low enable for driving the shift-value port |
| sv_out | output | AMT_W | Normalise count presented on the port |
| sv_drive | output | 1 | Port is driven by the block |
| sv_listen | output | 1 | Executing opcode reads the port |

## Verification
Two functions share a clock edge in this block. On one edge an amount register is written by a retiring load or normalise-and-store instruction. On the same edge an instruction that shifts by that register enters the execute stage directly behind it. The bench provokes this by streaming a load of R1 and a shift by R1 on consecutive edges. It judges the second result against a distance equal to the newly loaded value, not the old one. A second case stalls the output with a beat waiting in both stages. That beat must keep its data steady and hold `in_ready` low, and both results must then leave in order.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [3:0] {
    OP_SRL_V  = 4'h0,
    OP_SLL_V  = 4'h1,
    OP_ROR_V  = 4'h2,
    OP_ROL_V  = 4'h3,
    OP_SRL_A  = 4'h4,
    OP_SLL_A  = 4'h5,
    OP_SRL_B  = 4'h6,
    OP_SLL_B  = 4'h7,
    OP_LOAD_A = 4'h8,
    OP_LOAD_B = 4'h9,
    OP_SRA_V  = 4'hA,
    OP_SRA_A  = 4'hB,
    OP_SRA_B  = 4'hC,
    OP_NORM   = 4'hD,
    OP_NORM_A = 4'hE,
    OP_NORM_B = 4'hF
  } op_e;

  typedef enum logic [1:0] {
    SH_PASS = 2'd0,
    SH_LOG  = 2'd1,
    SH_ARI  = 2'd2,
    SH_ROT  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    SRC_PORT = 2'd0,
    SRC_REGA = 2'd1,
    SRC_REGB = 2'd2,
    SRC_LEAD = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    PORT_HIZ = 2'd0,
    PORT_IN  = 2'd1,
    PORT_OUT = 2'd2
  } pmode_e;

  typedef struct packed {
    kind_e  kind;
    logic   left;
    src_e   src;
    logic   wr_a;
    logic   wr_b;
    logic   wr_lead;
    pmode_e pmode;
  } dec_t;

endpackage

// File: rtl/nbs_decode.sv
module nbs_decode
  import nbs_pkg::*;
(
  input  op_e  op,
  output dec_t dec
);

  always_comb begin
    dec = '{kind: SH_PASS, left: 1'b0, src: SRC_PORT,
            wr_a: 1'b0, wr_b: 1'b0, wr_lead: 1'b0, pmode: PORT_HIZ};
    case (op)
      OP_SRL_V:  begin dec.kind = SH_LOG; dec.pmode = PORT_IN; end
      OP_SLL_V:  begin dec.kind = SH_LOG; dec.left = 1'b1; dec.pmode = PORT_IN; end
      OP_ROR_V:  begin dec.kind = SH_ROT; dec.pmode = PORT_IN; end
      OP_ROL_V:  begin dec.kind = SH_ROT; dec.left = 1'b1; dec.pmode = PORT_IN; end
      OP_SRL_A:  begin dec.kind = SH_LOG; dec.src = SRC_REGA; end
      OP_SLL_A:  begin dec.kind = SH_LOG; dec.left = 1'b1; dec.src = SRC_REGA; end
      OP_SRL_B:  begin dec.kind = SH_LOG; dec.src = SRC_REGB; end
      OP_SLL_B:  begin dec.kind = SH_LOG; dec.left = 1'b1; dec.src = SRC_REGB; end
      OP_LOAD_A: begin dec.wr_a = 1'b1; dec.pmode = PORT_IN; end
      OP_LOAD_B: begin dec.wr_b = 1'b1; dec.pmode = PORT_IN; end
      OP_SRA_V:  begin dec.kind = SH_ARI; dec.pmode = PORT_IN; end
      OP_SRA_A:  begin dec.kind = SH_ARI; dec.src = SRC_REGA; end
      OP_SRA_B:  begin dec.kind = SH_ARI; dec.src = SRC_REGB; end
      OP_NORM:   begin
        dec.kind = SH_LOG; dec.left = 1'b1; dec.src = SRC_LEAD; dec.pmode = PORT_OUT;
      end
      OP_NORM_A: begin
        dec.kind = SH_LOG; dec.left = 1'b1; dec.src = SRC_LEAD; dec.pmode = PORT_OUT;
        dec.wr_a = 1'b1; dec.wr_lead = 1'b1;
      end
      OP_NORM_B: begin
        dec.kind = SH_LOG; dec.left = 1'b1; dec.src = SRC_LEAD; dec.pmode = PORT_OUT;
        dec.wr_b = 1'b1; dec.wr_lead = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/nbs_lead.sv
module nbs_lead #(
  parameter int DATA_W = 16,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d,
  output logic [AMT_W-1:0]  amt,
  output logic              flat
);

  logic run;

  // count copies of the sign bit below it, stopping at the first change
  always_comb begin
    amt = '0;
    run = 1'b1;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (run && (d[i] == d[DATA_W-1])) amt = amt + AMT_W'(1);
      else                              run = 1'b0;
    end
  end

  // independent detection of a word with no sign boundary
  assign flat = (d == '0) || (d == '1);

endmodule

// File: rtl/nbs_core.sv
module nbs_core
  import nbs_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d,
  input  kind_e             kind,
  input  logic              left,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] q
);

  logic [2*DATA_W-1:0] dd, rl, rr;

  always_comb begin
    dd = {d, d};
    rl = dd << amt;
    rr = dd >> amt;
    case (kind)
      SH_LOG:  q = left ? (d << amt) : (d >> amt);
      SH_ARI:  q = left ? (d << amt) : DATA_W'($signed(d) >>> amt);
      SH_ROT:  q = left ? rl[2*DATA_W-1:DATA_W] : rr[DATA_W-1:0];
      default: q = d;
    endcase
  end

endmodule

// File: rtl/norm_barrel_shifter.sv
module norm_barrel_shifter
  import nbs_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AMT_W-1:0]  in_sv,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              sv_oe_n,
  output logic [AMT_W-1:0]  sv_out,
  output logic              sv_drive,
  output logic              sv_listen
);

  // execute stage
  logic              s1_v;
  op_e               s1_op;
  logic [DATA_W-1:0] s1_d;
  logic [AMT_W-1:0]  s1_sv;
  // amount registers
  logic [AMT_W-1:0]  amt_a, amt_b;
  // output stage
  logic              o_v;
  logic [DATA_W-1:0] o_d;

  dec_t              dec;
  logic [AMT_W-1:0]  lead_amt, amt;
  logic              flat;
  logic [DATA_W-1:0] shifted;
  logic              adv, take;

  nbs_decode u_dec (.op(s1_op), .dec(dec));

  nbs_lead #(.DATA_W(DATA_W)) u_lead (.d(s1_d), .amt(lead_amt), .flat(flat));

  always_comb begin
    case (dec.src)
      SRC_PORT: amt = s1_sv;
      SRC_REGA: amt = amt_a;
      SRC_REGB: amt = amt_b;
      default:  amt = lead_amt;
    endcase
  end

  nbs_core #(.DATA_W(DATA_W)) u_core (
    .d(s1_d), .kind(dec.kind), .left(dec.left), .amt(amt), .q(shifted)
  );

  // handshake
  assign adv      = s1_v && (!o_v || out_ready);
  assign in_ready = !s1_v || adv;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      s1_v  <= 1'b0;
      s1_op <= OP_SRL_V;
      s1_d  <= '0;
      s1_sv <= '0;
    end else begin
      if (in_ready) s1_v <= in_valid;
      if (take) begin
        s1_op <= op_e'(in_op);
        s1_d  <= in_data;
        s1_sv <= in_sv;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      amt_a <= '0;
      amt_b <= '0;
    end else if (adv) begin
      if (dec.wr_a) amt_a <= dec.wr_lead ? lead_amt : s1_sv;
      if (dec.wr_b) amt_b <= dec.wr_lead ? lead_amt : s1_sv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      o_v <= 1'b0;
      o_d <= '0;
    end else if (adv) begin
      o_v <= 1'b1;
      o_d <= shifted;
    end else if (out_ready) begin
      o_v <= 1'b0;
    end
  end

  assign out_valid = o_v;
  assign out_data  = o_d;

  // shift-value port
  assign sv_out    = (s1_v && dec.pmode == PORT_OUT) ? lead_amt : '0;
  assign sv_drive  = s1_v && (dec.pmode == PORT_OUT) && !sv_oe_n;
  assign sv_listen = s1_v && (dec.pmode == PORT_IN);

  // ---------------- assertions ----------------
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_valid && in_ready && amt_a == '0 && amt_b == '0));

  assert_load_a_R6: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (adv && s1_op == OP_LOAD_A) |=> (amt_a == $past(s1_sv)));

  assert_norm_sign_R7: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (adv && dec.src == SRC_LEAD && !flat) |=> (out_data[DATA_W-1] != out_data[DATA_W-2]));

  assert_flat_max_R8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (s1_v && flat) |-> (lead_amt == AMT_W'(DATA_W - 1)));

  assert_store_b_R9: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (adv && s1_op == OP_NORM_B) |=> (amt_b == $past(lead_amt)));

  assert_port_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sv_drive && sv_listen));

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n || clr)
    take |=> s1_v);

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_full_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/norm_barrel_shifter_bench.sv
module norm_barrel_shifter_bench;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    in_op = '0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] in_sv = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          sv_oe_n = 1'b0;
  logic [AW-1:0] sv_out;
  logic          sv_drive, sv_listen;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  norm_barrel_shifter #(.DATA_W(DW)) u_norm_barrel_shifter (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_data(in_data), .in_sv(in_sv),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sv_oe_n(sv_oe_n), .sv_out(sv_out), .sv_drive(sv_drive), .sv_listen(sv_listen)
  );

  // {op, data, sv, expected, port mode (0 hiz,1 in,2 out), expected sv_out}
  localparam logic [45:0] VEC [NV] = '{
    {4'h0, 16'hF0F0, 4'd4,  16'h0F0F, 2'd1, 4'd0},   // R2
    {4'h1, 16'h8421, 4'd3,  16'h2108, 2'd1, 4'd0},   // R2
    {4'h2, 16'h1234, 4'd4,  16'h4123, 2'd1, 4'd0},   // R3
    {4'h3, 16'h8001, 4'd1,  16'h0003, 2'd1, 4'd0},   // R3
    {4'hA, 16'h8000, 4'd15, 16'hFFFF, 2'd1, 4'd0},   // R4
    {4'hA, 16'h7FFF, 4'd3,  16'h0FFF, 2'd1, 4'd0},   // R4
    {4'h8, 16'hABCD, 4'd5,  16'hABCD, 2'd1, 4'd0},   // R6 R1=5
    {4'h4, 16'hFF00, 4'd0,  16'h07F8, 2'd0, 4'd0},   // R5
    {4'h9, 16'h1357, 4'd2,  16'h1357, 2'd1, 4'd0},   // R6 R2=2
    {4'h7, 16'h0F01, 4'd0,  16'h3C04, 2'd0, 4'd0},   // R5
    {4'hB, 16'h8010, 4'd0,  16'hFC00, 2'd0, 4'd0},   // R4
    {4'hC, 16'hF000, 4'd0,  16'hFC00, 2'd0, 4'd0},   // R4
    {4'h5, 16'h0003, 4'd0,  16'h0060, 2'd0, 4'd0},   // R5
    {4'h6, 16'h0300, 4'd0,  16'h00C0, 2'd0, 4'd0},   // R5
    {4'hD, 16'h0001, 4'd0,  16'h4000, 2'd2, 4'd14},  // R7
    {4'hE, 16'h00F0, 4'd0,  16'h7800, 2'd2, 4'd7},   // R9 R1=7
    {4'h4, 16'h8000, 4'd0,  16'h0100, 2'd0, 4'd0},   // R9 readback
    {4'hF, 16'hFFFF, 4'd0,  16'h8000, 2'd2, 4'd15},  // R8 R2=15
    {4'h6, 16'h8000, 4'd0,  16'h0001, 2'd0, 4'd0},   // R9 readback
    {4'hD, 16'h0000, 4'd0,  16'h0000, 2'd2, 4'd15},  // R8
    {4'hD, 16'hE000, 4'd0,  16'h8000, 2'd2, 4'd2},   // R7
    {4'hD, 16'h4000, 4'd0,  16'h4000, 2'd2, 4'd0}    // R7
  };

  function automatic string op_req(input logic [3:0] op);
    case (op)
      4'h0, 4'h1:       return "R2";
      4'h2, 4'h3:       return "R3";
      4'hA, 4'hB, 4'hC: return "R4";
      4'h8, 4'h9:       return "R6";
      4'hD:             return "R7";
      4'hE, 4'hF:       return "R9";
      default:          return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one beat on an empty pipeline with out_ready high
  task automatic run(input logic [3:0] op, input logic [DW-1:0] d, input logic [AW-1:0] sv,
                     input logic [DW-1:0] exp, input logic [1:0] mode,
                     input logic [AW-1:0] svo, input bit chk_port);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = d; in_sv = sv;
    @(negedge clk);
    in_valid = 1'b0;
    if (chk_port) begin
      chk("R10", "sv_listen", 32'(sv_listen), 32'(mode == 2'd1));
      chk("R10", "sv_drive",  32'(sv_drive),  32'(mode == 2'd2 && !sv_oe_n));
      if (mode == 2'd2) chk("R10", "sv_out", 32'(sv_out), 32'(svo));
    end
    @(negedge clk);
    chk("R11", "out_valid", 32'(out_valid), 32'd1);
    chk(op_req(op), "out_data", 32'(out_data), 32'(exp));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);
    run(4'h4, 16'h8000, 4'd0, 16'h8000, 2'd0, 4'd0, 1'b1);  // R1 amount reg A zero
    run(4'h6, 16'h8000, 4'd0, 16'h8000, 2'd0, 4'd0, 1'b1);  // R1 amount reg B zero

    // table walk
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][45:42], VEC[i][41:26], VEC[i][25:22], VEC[i][21:6],
          VEC[i][5:4], VEC[i][3:0], 1'b1);
    end

    // R10: enable high keeps the port undriven on a normalise opcode
    sv_oe_n = 1'b1;
    run(4'hD, 16'h0001, 4'd0, 16'h4000, 2'd2, 4'd14, 1'b1);
    sv_oe_n = 1'b0;

    // R11 / R6: load R1 and shift by it on consecutive edges
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'h8; in_data = 16'h1111; in_sv = 4'd3;
    @(negedge clk);
    chk("R11", "in_ready back-to-back", 32'(in_ready), 32'd1);
    in_op = 4'h4; in_data = 16'h0080; in_sv = 4'd0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "first out_valid", 32'(out_valid), 32'd1);
    chk("R6", "load passes data", 32'(out_data), 32'h1111);
    @(negedge clk);
    chk("R11", "second out_valid", 32'(out_valid), 32'd1);
    chk("R6", "shift sees new R1", 32'(out_data), 32'h0010);
    @(negedge clk);
    chk("R11", "drained", 32'(out_valid), 32'd0);

    // R12: back-pressure with both stages full
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'h0; in_data = 16'h00FF; in_sv = 4'd4;
    @(negedge clk);
    in_op = 4'h1; in_data = 16'h0001; in_sv = 4'd1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R12", "in_ready when full", 32'(in_ready), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12", "held out_valid", 32'(out_valid), 32'd1);
      chk("R12", "held out_data", 32'(out_data), 32'h000F);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R12", "second beat valid", 32'(out_valid), 32'd1);
    chk("R12", "second beat data", 32'(out_data), 32'h0002);
    @(negedge clk);
    chk("R12", "drained", 32'(out_valid), 32'd0);

    // R1: synchronous clear with a pending output and a loaded R1
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'h8; in_data = 16'h5555; in_sv = 4'd9;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1", "pending before clear", 32'(out_valid), 32'd1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R1", "out_valid after clear", 32'(out_valid), 32'd0);
    chk("R1", "in_ready after clear", 32'(in_ready), 32'd1);
    out_ready = 1'b1;
    run(4'h4, 16'h8000, 4'd0, 16'h8000, 2'd0, 4'd0, 1'b0);  // R1 cleared amount reg

    finish_run();
  end

endmodule